// File: doc/BRIEF.md
# Receive-Line Density Reset Generator

This block watches an idle-high asynchronous receive line and raises a reset for a soft processor core when the line stays mostly low for a sustained stretch. A host starts such a stretch by sending a run of all-zero (or nearly all-zero) characters. Ordinary loader traffic keeps a good share of high bits on the line and never starts a reset. The block measures the share of high time with a weighted up/down counter that saturates at both ends. The counter climbs by `UP_STEP` on every cycle the synchronised line is high and falls by `DN_STEP` on every cycle it is low. With the default 3:1 weighting, the counter drifts down only when fewer than about a quarter of the cycles are high.

A reset that starts is held for a minimum number of cycles. After that, it is released only once the counter has climbed back past a separate, higher release level, so a line hovering near the trigger level cannot toggle the reset. An optional active-low request line of the modem-control kind can also assert reset on its own. The core reset pin is active low: it is high only when the line detector is idle and that request is inactive. Whichever of the two sources lets go last sets the release time. A status LED shows the reset, and a low `enable` parks the line detector in its idle state.

Top module: `brk_rst_gen`

## Requirements
- R1: The receive line passes through a `SYNC_STAGES`-flop synchroniser that resets to 1. The density counter resets to its maximum (255 by default). On each enabled cycle it adds `UP_STEP` (3) when the synchronised line is high and subtracts `DN_STEP` (1) when it is low, saturating at 0 and at the maximum.
- R2: Traffic with at least 40% high cycles, repeated for any length of time, never asserts reset.
- R3: The line detector starts a reset in the cycle after the counter is below `LOW_THR` (32). Starting from a full counter, 224 consecutive low cycles start a reset; 223 low cycles followed by a high line do not.
- R4: A burst with about 10% or 20% high cycles, long enough to drain the counter, starts a reset.
- R5: Once started, a line reset lasts at least `HOLD_CYC` cycles. If the counter has already recovered by then, the line reset lasts `HOLD_CYC`+1 cycles.
- R6: After the hold time, the line reset stays asserted until the counter reaches `REL_THR` (192). From an empty counter with the line driven high, release follows about 64 high cycles later.
- R7: `core_rst_n` is low whenever the line detector holds reset or the synchronised `dtr_n` is low. A low `dtr_n` pulls `core_rst_n` low within two cycles. When both sources are active, reset lasts until the later one lets go.
- R8: While `enable` is low, the line detector is idle and its counter is forced to the maximum. Lowering `enable` ends a line reset on the next cycle. The `dtr_n` path is unaffected.
- R9: `led` is always the inverse of `core_rst_n`.
- R10: During and right after reset, `core_rst_n` is 1 and `led` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous receive line, idle high |
| dtr_n | input | 1 | Optional active-low reset request, asynchronous |
| enable | input | 1 | High to run the line detector |
| core_rst_n | output | 1 | Active-low reset for the core |
| led | output | 1 | Status LED, high while the core is held in reset |

## Verification
The line detector and the request input can hold reset in the same cycles, and the key question is which one sets the release time. The bench first starts a line reset with a low burst and then pulls `dtr_n` low while the hold timer is still running. It keeps `dtr_n` low until well after the line path has let go, and checks that `core_rst_n` stays low until the request clears and then rises within a few cycles. Within the line path, the minimum-hold timer and the recovery level also meet in the same cycle. The bench tests this by keeping the line low past the hold time and confirming that the reset is released only once the counter has refilled.

// File: rtl/brk_rst_pkg.sv
package brk_rst_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_HOLD    = 2'd1,
      ST_RECOVER = 2'd2
   } brk_state_e;
endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("brk_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      logic q_r;
      always_ff @(posedge clk) begin
         if (rst) q_r <= RST_VAL;
         else     q_r <= d;
      end
      assign q = q_r;
   end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (rst) chain <= {STAGES{RST_VAL}};
         else     chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/brk_density.sv
module brk_density #(
   parameter int CNT_W   = 8,
   parameter int UP_STEP = 3,
   parameter int DN_STEP = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             bit_i,
   output logic [CNT_W-1:0] level_o
);
   localparam int               MAXV  = (2 ** CNT_W) - 1;
   localparam logic [CNT_W:0]   UP_E  = (CNT_W+1)'(UP_STEP);
   localparam logic [CNT_W:0]   MAX_E = (CNT_W+1)'(MAXV);
   localparam logic [CNT_W-1:0] DN_V  = CNT_W'(DN_STEP);
   localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAXV);

   logic [CNT_W-1:0] level_q;
   logic [CNT_W-1:0] level_d;
   logic [CNT_W:0]   sum_up;

   always_comb begin
      sum_up = {1'b0, level_q} + UP_E;
      if (!en) begin
         level_d = MAX_V;
      end else if (bit_i) begin
         level_d = (sum_up > MAX_E) ? MAX_V : sum_up[CNT_W-1:0];
      end else begin
         level_d = (level_q < DN_V) ? '0 : (level_q - DN_V);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) level_q <= MAX_V;
      else     level_q <= level_d;
   end

   assign level_o = level_q;
endmodule

// File: rtl/brk_hold_ctl.sv
module brk_hold_ctl
   import brk_rst_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int LOW_THR  = 32,
   parameter int REL_THR  = 192,
   parameter int HOLD_CYC = 1000
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [CNT_W-1:0] level_i,
   output logic             line_rst_o
);
   localparam int               HOLD_W = $clog2(HOLD_CYC);
   localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYC - 1);
   localparam logic [CNT_W-1:0] LOW_V = CNT_W'(LOW_THR);
   localparam logic [CNT_W-1:0] REL_V = CNT_W'(REL_THR);

   brk_state_e        state_q, state_d;
   logic [HOLD_W-1:0] hold_q, hold_d;

   always_comb begin
      state_d = state_q;
      hold_d  = hold_q;
      if (!en) begin
         state_d = ST_IDLE;
         hold_d  = '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (level_i < LOW_V) begin
                  state_d = ST_HOLD;
                  hold_d  = HOLD_LOAD;
               end
            end
            ST_HOLD: begin
               if (hold_q == '0) state_d = ST_RECOVER;
               else              hold_d  = hold_q - 1'b1;
            end
            ST_RECOVER: begin
               if (level_i >= REL_V) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         hold_q  <= '0;
      end else begin
         state_q <= state_d;
         hold_q  <= hold_d;
      end
   end

   assign line_rst_o = (state_q != ST_IDLE);
endmodule

// File: rtl/brk_rst_gen.sv
module brk_rst_gen #(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 8,
   parameter int UP_STEP     = 3,
   parameter int DN_STEP     = 1,
   parameter int LOW_THR     = 32,
   parameter int REL_THR     = 192,
   parameter int HOLD_CYC    = 1000,
   parameter bit HAS_DTR     = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic rxd,
   input  logic dtr_n,
   input  logic enable,
   output logic core_rst_n,
   output logic led
);
   localparam int CNT_MAX = (2 ** CNT_W) - 1;

   if (UP_STEP < 1 || DN_STEP < 1) begin : g_bad_step
      $error("brk_rst_gen: step sizes must be positive");
   end
   if (UP_STEP > CNT_MAX || DN_STEP > CNT_MAX) begin : g_bad_step_w
      $error("brk_rst_gen: step sizes exceed counter range");
   end
   if (LOW_THR < 1 || LOW_THR >= REL_THR) begin : g_bad_thr
      $error("brk_rst_gen: need 0 < LOW_THR < REL_THR");
   end
   if (REL_THR > CNT_MAX) begin : g_bad_rel
      $error("brk_rst_gen: REL_THR exceeds counter range");
   end
   if (HOLD_CYC < 2) begin : g_bad_hold
      $error("brk_rst_gen: HOLD_CYC must be at least 2");
   end

   logic             rxd_s;
   logic             dtr_ok;
   logic [CNT_W-1:0] level;
   logic             line_rst;

   brk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxd_sync (
      .clk (clk),
      .rst (rst),
      .d   (rxd),
      .q   (rxd_s)
   );

   if (HAS_DTR) begin : g_dtr
      brk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dtr_sync (
         .clk (clk),
         .rst (rst),
         .d   (dtr_n),
         .q   (dtr_ok)
      );
   end else begin : g_no_dtr
      logic unused_dtr;
      assign unused_dtr = dtr_n;
      assign dtr_ok     = 1'b1;
   end

   brk_density #(.CNT_W(CNT_W), .UP_STEP(UP_STEP), .DN_STEP(DN_STEP)) u_density (
      .clk     (clk),
      .rst     (rst),
      .en      (enable),
      .bit_i   (rxd_s),
      .level_o (level)
   );

   brk_hold_ctl #(
      .CNT_W    (CNT_W),
      .LOW_THR  (LOW_THR),
      .REL_THR  (REL_THR),
      .HOLD_CYC (HOLD_CYC)
   ) u_hold (
      .clk        (clk),
      .rst        (rst),
      .en         (enable),
      .level_i    (level),
      .line_rst_o (line_rst)
   );

   assign core_rst_n = ~line_rst & dtr_ok;
   assign led        = ~core_rst_n;
endmodule

// File: rtl/brk_rst_gen_chk.sv
module brk_rst_gen_chk #(
   parameter int CNT_W    = 8,
   parameter int UP_STEP  = 3,
   parameter int DN_STEP  = 1,
   parameter int LOW_THR  = 32,
   parameter int REL_THR  = 192,
   parameter int HOLD_CYC = 1000,
   parameter bit HAS_DTR  = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             enable,
   input logic             dtr_n,
   input logic             core_rst_n,
   input logic             led,
   input logic             line_rst,
   input logic [CNT_W-1:0] level
);
   localparam int MAXV = (2 ** CNT_W) - 1;

   logic [1:0] since;
   int         rst_len;

   always_ff @(posedge clk) begin
      if (rst) since <= '0;
      else if (since != 2'd3) since <= since + 2'd1;
   end

   always_ff @(posedge clk) begin
      if (rst || !line_rst) rst_len <= 0;
      else                  rst_len <= rst_len + 1;
   end

   // R1: counter moves only by the configured steps or saturates
   a_r1_step: assert property (@(posedge clk) disable iff (rst)
      (since != 2'd0 && enable && $past(enable)) |->
         (int'(level) == int'($past(level)) + UP_STEP ||
          int'(level) == int'($past(level)) - DN_STEP ||
          int'(level) == MAXV || int'(level) == 0));

   // R3: a line reset only starts from a level below the trigger
   a_r3_entry_low: assert property (@(posedge clk) disable iff (rst)
      (since != 2'd0 && $rose(line_rst)) |-> (int'($past(level)) < LOW_THR));

   // R5: no line reset shorter than the hold time unless disabled
   a_r5_min_hold: assert property (@(posedge clk) disable iff (rst)
      (since != 2'd0 && $fell(line_rst) && $past(enable)) |-> (rst_len >= HOLD_CYC));

   // R6: release only after recovery past the release level
   a_r6_release_level: assert property (@(posedge clk) disable iff (rst)
      (since != 2'd0 && $fell(line_rst)) |->
         (!$past(enable) || int'($past(level)) >= REL_THR));

   // R7: line reset always reaches the core
   a_r7_line_drives: assert property (@(posedge clk) disable iff (rst)
      line_rst |-> !core_rst_n);

   // R8: disabled detector holds no reset
   a_r8_disable_idle: assert property (@(posedge clk) disable iff (rst)
      (since != 2'd0 && !$past(enable)) |-> !line_rst);

   // R9: LED opposite of the reset pin
   a_r9_led: assert property (@(posedge clk) disable iff (rst)
      led != core_rst_n);

   if (HAS_DTR) begin : g_dtr_chk
      // R7: request seen two cycles ago forces reset
      a_r7_dtr: assert property (@(posedge clk) disable iff (rst)
         (since == 2'd3 && !$past(dtr_n, 2)) |-> !core_rst_n);
   end
endmodule

bind brk_rst_gen brk_rst_gen_chk #(
   .CNT_W    (CNT_W),
   .UP_STEP  (UP_STEP),
   .DN_STEP  (DN_STEP),
   .LOW_THR  (LOW_THR),
   .REL_THR  (REL_THR),
   .HOLD_CYC (HOLD_CYC),
   .HAS_DTR  (HAS_DTR)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .enable     (enable),
   .dtr_n      (dtr_n),
   .core_rst_n (core_rst_n),
   .led        (led),
   .line_rst   (line_rst),
   .level      (level)
);

// File: tb/brk_rst_gen_tb_top.sv
`timescale 1ns/1ps
module brk_rst_gen_tb_top;
   localparam int HOLD = 1000;
   localparam int NV   = 8;
   // high cycles, period, periods, expect reset
   localparam int VEC [0:NV-1][0:3] = '{
      '{2, 5, 200, 0},
      '{1, 2, 300, 0},
      '{1, 1, 200, 0},
      '{4, 10, 200, 0},
      '{3, 10, 300, 0},
      '{1, 10, 60, 1},
      '{0, 9, 40, 1},
      '{1, 5, 300, 1}
   };

   logic clk = 1'b0;
   logic rst, rxd, dtr_n, enable;
   logic core_rst_n, led;
   int   total = 0;
   int   bad   = 0;
   logic seen;

   always #10 clk = ~clk;

   brk_rst_gen #(.HOLD_CYC(HOLD)) dut_i (
      .clk        (clk),
      .rst        (rst),
      .rxd        (rxd),
      .dtr_n      (dtr_n),
      .enable     (enable),
      .core_rst_n (core_rst_n),
      .led        (led)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (led) seen = 1'b1;
         chk(led == !core_rst_n, "R9 led mirror", int'(led), int'(!core_rst_n));
      end
   endtask

   task automatic clr();
      rxd = 1'b1; dtr_n = 1'b1; enable = 1'b0;
      step(4);
      enable = 1'b1;
      step(2);
      seen = 1'b0;
   endtask

   task automatic run(input int hi, input int per, input int nper);
      for (int p = 0; p < nper; p++)
         for (int i = 0; i < per; i++) begin
            rxd = (i < hi);
            step(1);
         end
   endtask

   initial begin
      #(20.0 * 200000);
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1'b1; rxd = 1'b1; dtr_n = 1'b1; enable = 1'b1; seen = 1'b0;
      repeat (5) @(negedge clk);
      chk(core_rst_n == 1'b1 && led == 1'b0, "R10 in reset", int'(core_rst_n), 1);
      rst = 1'b0;
      @(negedge clk);
      chk(core_rst_n == 1'b1 && led == 1'b0, "R10 after reset", int'(core_rst_n), 1);

      // R2 R4 density table
      for (int v = 0; v < NV; v++) begin
         clr();
         run(VEC[v][0], VEC[v][1], VEC[v][2]);
         rxd = 1'b1;
         step(5);
         chk(int'(seen) == VEC[v][3],
             (VEC[v][3] != 0) ? "R4 burst triggers" : "R2 traffic ignored",
             int'(seen), VEC[v][3]);
      end

      // R3 boundary: 223 low cycles
      clr();
      run(0, 1, 223);
      rxd = 1'b1;
      step(10);
      chk(seen == 1'b0, "R3 223 lows no reset", int'(seen), 0);
      // R3 boundary: 224 low cycles
      clr();
      run(0, 1, 224);
      rxd = 1'b1;
      step(5);
      chk(seen == 1'b1, "R3 224 lows reset", int'(seen), 1);

      // R5 width with prompt recovery
      begin
         int w;
         clr();
         run(0, 1, 224);
         rxd = 1'b1;
         w = 0;
         for (int i = 0; i < 3000; i++) begin
            step(1);
            if (led) w++;
            if (w > 0 && !led) break;
         end
         chk(w >= HOLD && w <= HOLD + 2, "R5 reset width", w, HOLD + 1);
      end

      // R6 hysteresis
      clr();
      run(0, 1, 1300);
      chk(led == 1'b1, "R6 held while low", int'(led), 1);
      rxd = 1'b1;
      step(60);
      chk(core_rst_n == 1'b0, "R6 held before recovery", int'(core_rst_n), 0);
      step(12);
      chk(core_rst_n == 1'b1, "R6 released after recovery", int'(core_rst_n), 1);

      // R7 request alone
      clr();
      dtr_n = 1'b0;
      step(3);
      chk(core_rst_n == 1'b0, "R7 dtr asserts", int'(core_rst_n), 0);
      dtr_n = 1'b1;
      step(3);
      chk(core_rst_n == 1'b1, "R7 dtr releases", int'(core_rst_n), 1);

      // R7 both sources, request released last
      clr();
      run(0, 1, 224);
      rxd = 1'b1;
      dtr_n = 1'b0;
      step(1200);
      chk(core_rst_n == 1'b0, "R7 later source holds", int'(core_rst_n), 0);
      dtr_n = 1'b1;
      step(4);
      chk(core_rst_n == 1'b1, "R7 release after both", int'(core_rst_n), 1);

      // R8 enable
      clr();
      enable = 1'b0;
      run(0, 1, 600);
      chk(seen == 1'b0, "R8 disabled no reset", int'(seen), 0);
      enable = 1'b1;
      run(0, 1, 200);
      chk(seen == 1'b0, "R8 counter refilled", int'(seen), 0);
      run(0, 1, 40);
      step(5);
      chk(seen == 1'b1, "R8 triggers once enabled", int'(seen), 1);
      enable = 1'b0;
      step(2);
      chk(core_rst_n == 1'b1, "R8 disable releases", int'(core_rst_n), 1);
      dtr_n = 1'b0;
      step(3);
      chk(core_rst_n == 1'b0, "R8 dtr path still active", int'(core_rst_n), 0);
      dtr_n = 1'b1;
      enable = 1'b1;
      rxd = 1'b1;
      step(4);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule